// File: doc/BRIEF.md
# Transmit Frame Buffer Life-Cycle Controller

This block follows one transmit frame buffer through its whole life: from empty, through being offered for arbitration, being sent by the protocol engine, and finishing as sent, failed or aborted. Software drives it with three single-cycle strobes: mark ready, mark empty and request abort. The protocol engine drives it with a lock strobe when it starts sending the buffer. It also raises an unlock strobe with a two-bit cause when the attempt ends.

The block presents its state as a 3-bit code. It also gives a flag that says the buffer may enter arbitration, and a one-cycle pulse each time the buffer reaches a final state. An error unlock sends the buffer back for another attempt until a retransmission count reaches a limit that the host supplies. The count is kept inside the block. When software and the engine act in the same cycle, the result is fixed by the precedence rules below.

Top module: `tx_buffer_fsm`

## Requirements
- R1: After reset `bufState` is 0 (empty), `readyForArb` is 0 and `stateIrq` is 0. The state codes are: empty 0, ready 1, sending 2, abort pending 3, aborted 4, failed 5, sent OK 6. Every state change shows on `bufState` one clock edge after the command that causes it.
- R2: `swSetReady` moves the buffer to ready from empty, aborted, failed or sent OK, and clears the retransmission count. In ready, sending or abort pending it is ignored.
- R3: `swSetEmpty` moves the buffer to empty from aborted, failed or sent OK. In every other state it is ignored. When it arrives together with `swSetReady`, the buffer goes to ready.
- R4: `hwLock` in ready moves the buffer to sending. In any other state it is ignored.
- R5: `swSetAbort` alone in ready moves the buffer to aborted. In sending without an unlock it moves the buffer to abort pending. In the other states it is ignored.
- R6: `hwLock` and `swSetAbort` in the same cycle in ready move the buffer to abort pending.
- R7: `hwUnlock` in sending, with no abort request, acts on `hwUnlockCause` (0 success, 1 error, 2 arbitration lost, 3 engine abort). Success goes to sent OK, arbitration lost goes to ready, and engine abort goes to aborted. Error goes to failed when the retransmission count is at least `retxLimit`. Otherwise it goes to ready and the count goes up by one.
- R8: `hwUnlock` in abort pending goes to sent OK on success and to aborted for any other cause. An unlock that arrives in sending together with `swSetAbort` gets the same treatment.
- R9: `hwUnlock` in empty, ready, aborted, failed or sent OK is ignored.
- R10: `readyForArb` is 1 exactly while `bufState` is ready.
- R11: `stateIrq` is high for one cycle, in the first cycle that `bufState` shows a newly entered aborted, failed or sent OK state. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swSetReady | input | 1 | Software strobe: offer buffer for transmission |
| swSetEmpty | input | 1 | Software strobe: release buffer |
| swSetAbort | input | 1 | Software strobe: abort request |
| hwLock | input | 1 | Engine strobe: transmission of this buffer starts |
| hwUnlock | input | 1 | Engine strobe: transmission attempt ends |
| hwUnlockCause | input | 2 | Unlock cause: 0 ok, 1 error, 2 arbitration lost, 3 engine abort |
| retxLimit | input | CNT_W | Allowed retransmissions after error |
| bufState | output | 3 | Current state code |
| readyForArb | output | 1 | Buffer may take part in arbitration |
| stateIrq | output | 1 | One-cycle pulse on entry to a final state |

## Verification
The bench goes after the races between software and engine. A lock and an abort in the same cycle must give abort pending; a design that lets the abort win would report aborted while the engine is still sending. An abort that coincides with a failing unlock must end in aborted and not back in ready or failed. Error unlocks are run with limits 0 and 1 and with the limit changed during a run, so an off-by-one in the retransmission count shows up as one attempt too many or too few. The bench also checks that the completion pulse fires once per entry and never while a final state is held.

// File: rtl/txb_pkg.sv
package txb_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY   = 3'd0,
    ST_READY   = 3'd1,
    ST_SENDING = 3'd2,
    ST_ABPEND  = 3'd3,
    ST_ABORTED = 3'd4,
    ST_FAILED  = 3'd5,
    ST_DONE    = 3'd6
  } txbState_e;

  typedef enum logic [1:0] {
    CAUSE_OK    = 2'd0,
    CAUSE_ERR   = 2'd1,
    CAUSE_ARB   = 2'd2,
    CAUSE_ABORT = 2'd3
  } unlockCause_e;

  typedef struct packed {
    txbState_e nextState;
    logic      clrRetry;
    logic      incRetry;
    logic      raiseIrq;
  } txbStrobe_t;

  function automatic logic isFinal(txbState_e s);
    return (s == ST_ABORTED) || (s == ST_FAILED) || (s == ST_DONE);
  endfunction

endpackage

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  txbState_e  curState,
  input  logic       limitHit,
  input  logic       swSetReady,
  input  logic       swSetEmpty,
  input  logic       swSetAbort,
  input  logic       hwLock,
  input  logic       hwUnlock,
  input  logic [1:0] hwUnlockCause,
  output txbStrobe_t strobe
);

  unlockCause_e cause;
  txbState_e    nxt;
  logic         clr;
  logic         inc;

  assign cause = unlockCause_e'(hwUnlockCause);

  always_comb begin
    nxt = curState;
    clr = 1'b0;
    inc = 1'b0;
    unique case (curState)
      ST_EMPTY: begin
        if (swSetReady) begin
          nxt = ST_READY;
          clr = 1'b1;
        end
      end
      ST_READY: begin
        if (hwLock) begin
          nxt = swSetAbort ? ST_ABPEND : ST_SENDING;
        end else if (swSetAbort) begin
          nxt = ST_ABORTED;
        end
      end
      ST_SENDING: begin
        if (hwUnlock) begin
          if (swSetAbort) begin
            nxt = (cause == CAUSE_OK) ? ST_DONE : ST_ABORTED;
          end else begin
            unique case (cause)
              CAUSE_OK:    nxt = ST_DONE;
              CAUSE_ARB:   nxt = ST_READY;
              CAUSE_ABORT: nxt = ST_ABORTED;
              CAUSE_ERR: begin
                if (limitHit) begin
                  nxt = ST_FAILED;
                end else begin
                  nxt = ST_READY;
                  inc = 1'b1;
                end
              end
              default: nxt = curState;
            endcase
          end
        end else if (swSetAbort) begin
          nxt = ST_ABPEND;
        end
      end
      ST_ABPEND: begin
        if (hwUnlock) begin
          nxt = (cause == CAUSE_OK) ? ST_DONE : ST_ABORTED;
        end
      end
      ST_ABORTED, ST_FAILED, ST_DONE: begin
        if (swSetReady) begin
          nxt = ST_READY;
          clr = 1'b1;
        end else if (swSetEmpty) begin
          nxt = ST_EMPTY;
        end
      end
      default: nxt = ST_EMPTY;
    endcase
  end

  always_comb begin
    strobe.nextState = nxt;
    strobe.clrRetry  = clr;
    strobe.incRetry  = inc;
    strobe.raiseIrq  = (nxt != curState) && isFinal(nxt);
  end

  // R4
  lock_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_READY && hwLock) |=>
      (curState == ST_SENDING || curState == ST_ABPEND));

  // R5
  abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_READY && swSetAbort && !hwLock) |=> (curState == ST_ABORTED));

  // R2
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_EMPTY && !swSetReady) |=> (curState == ST_EMPTY));

  // R8
  abpend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_ABPEND && hwUnlock) |=>
      (curState == ST_DONE || curState == ST_ABORTED));

endmodule

// File: rtl/txb_dpath.sv
module txb_dpath
  import txb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  txbStrobe_t       strobe,
  input  logic [CNT_W-1:0] retxLimit,
  output txbState_e        stateQ,
  output logic             limitHit,
  output logic             irqQ
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] retryQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_EMPTY;
      irqQ   <= 1'b0;
      retryQ <= CNT_ZERO;
    end else begin
      stateQ <= strobe.nextState;
      irqQ   <= strobe.raiseIrq;
      if (strobe.clrRetry) begin
        retryQ <= CNT_ZERO;
      end else if (strobe.incRetry) begin
        retryQ <= retryQ + CNT_ONE;
      end
    end
  end

  assign limitHit = (retryQ >= retxLimit);

  // R11
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ |-> (isFinal(stateQ) && stateQ != $past(stateQ)));

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ |=> !irqQ);

  // R7
  failed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_FAILED && $past(stateQ) != ST_FAILED) |-> ($past(stateQ) == ST_SENDING));

endmodule

// File: rtl/tx_buffer_fsm.sv
module tx_buffer_fsm
  import txb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swSetReady,
  input  logic             swSetEmpty,
  input  logic             swSetAbort,
  input  logic             hwLock,
  input  logic             hwUnlock,
  input  logic [1:0]       hwUnlockCause,
  input  logic [CNT_W-1:0] retxLimit,
  output logic [2:0]       bufState,
  output logic             readyForArb,
  output logic             stateIrq
);

  txbStrobe_t strobe;
  txbState_e  stateQ;
  logic       limitHit;
  logic       irqQ;

  txb_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .curState      (stateQ),
    .limitHit      (limitHit),
    .swSetReady    (swSetReady),
    .swSetEmpty    (swSetEmpty),
    .swSetAbort    (swSetAbort),
    .hwLock        (hwLock),
    .hwUnlock      (hwUnlock),
    .hwUnlockCause (hwUnlockCause),
    .strobe        (strobe)
  );

  txb_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .retxLimit (retxLimit),
    .stateQ    (stateQ),
    .limitHit  (limitHit),
    .irqQ      (irqQ)
  );

  assign bufState    = stateQ;
  assign readyForArb = (stateQ == ST_READY);
  assign stateIrq    = irqQ;

  // R10
  arb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_READY && !hwLock && !swSetAbort) |=> readyForArb);

endmodule

// File: tb/tx_buffer_fsm_bench.sv
module tx_buffer_fsm_bench;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             swSetReady = 1'b0;
  logic             swSetEmpty = 1'b0;
  logic             swSetAbort = 1'b0;
  logic             hwLock = 1'b0;
  logic             hwUnlock = 1'b0;
  logic [1:0]       hwUnlockCause = 2'd0;
  logic [CNT_W-1:0] retxLimit = '0;
  logic [2:0]       bufState;
  logic             readyForArb;
  logic             stateIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mState = 0;
  int mCnt = 0;

  always #4 clk = ~clk;

  tx_buffer_fsm #(.CNT_W(CNT_W)) u_tx_buffer_fsm (
    .clk(clk), .rst_n(rst_n), .swSetReady(swSetReady), .swSetEmpty(swSetEmpty),
    .swSetAbort(swSetAbort), .hwLock(hwLock), .hwUnlock(hwUnlock),
    .hwUnlockCause(hwUnlockCause), .retxLimit(retxLimit), .bufState(bufState),
    .readyForArb(readyForArb), .stateIrq(stateIrq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit finalSt(int s);
    return s == 4 || s == 5 || s == 6;
  endfunction

  function automatic string tagFor(int s, bit sr, bit se, bit sa, bit lk, bit ul);
    if (s == 0) return ul ? "R9" : "R2";
    if (s == 1) begin
      if (lk && sa) return "R6";
      if (lk) return "R4";
      if (sa) return "R5";
      return ul ? "R9" : "R2";
    end
    if (s == 2) begin
      if (ul) return sa ? "R8" : "R7";
      return sa ? "R5" : "R4";
    end
    if (s == 3) return "R8";
    if (sr) return "R2";
    if (se) return "R3";
    return "R9";
  endfunction

  task automatic stepModel(bit sr, bit se, bit sa, bit lk, bit ul, int cs, int lim,
                           output int ns, output int nc);
    ns = mState;
    nc = mCnt;
    if (mState == 0) begin
      if (sr) begin ns = 1; nc = 0; end
    end else if (mState == 1) begin
      if (lk && sa) ns = 3;
      else if (lk) ns = 2;
      else if (sa) ns = 4;
    end else if (mState == 2) begin
      if (ul && sa) ns = (cs == 0) ? 6 : 4;
      else if (ul) begin
        if (cs == 0) ns = 6;
        else if (cs == 2) ns = 1;
        else if (cs == 3) ns = 4;
        else if (mCnt >= lim) ns = 5;
        else begin ns = 1; nc = mCnt + 1; end
      end else if (sa) ns = 3;
    end else if (mState == 3) begin
      if (ul) ns = (cs == 0) ? 6 : 4;
    end else begin
      if (sr) begin ns = 1; nc = 0; end
      else if (se) ns = 0;
    end
  endtask

  task automatic cycle(bit sr, bit se, bit sa, bit lk, bit ul, int cs);
    int ns, nc;
    bit expIrq;
    string tag;
    @(negedge clk);
    swSetReady = sr; swSetEmpty = se; swSetAbort = sa;
    hwLock = lk; hwUnlock = ul; hwUnlockCause = 2'(cs);
    stepModel(sr, se, sa, lk, ul, cs, int'(retxLimit), ns, nc);
    tag = tagFor(mState, sr, se, sa, lk, ul);
    expIrq = (ns != mState) && finalSt(ns);
    @(posedge clk);
    #1;
    mState = ns;
    mCnt = nc;
    check(tag, int'(bufState), mState);
    check("R10", int'(readyForArb), (mState == 1) ? 1 : 0);
    check("R11", int'(stateIrq), expIrq ? 1 : 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    check("R1", int'(bufState), 0);
    check("R1", int'(readyForArb), 0);
    check("R1", int'(stateIrq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corner cases
    retxLimit = 4'd0;
    cycle(0, 0, 0, 0, 1, 0);   // R9 unlock in empty ignored
    cycle(0, 1, 0, 1, 0, 0);   // R3 empty in empty ignored, R4 lock ignored
    cycle(1, 0, 0, 0, 0, 0);   // R2 to ready
    cycle(1, 0, 0, 0, 0, 0);   // R2 ignored in ready
    cycle(0, 0, 1, 1, 0, 0);   // R6 lock+abort
    cycle(0, 0, 0, 0, 1, 0);   // R8 ok -> done
    check("R11", int'(bufState), 6);
    cycle(0, 0, 0, 0, 0, 0);   // R11 no repeat pulse
    cycle(1, 1, 0, 0, 0, 0);   // R3 ready wins
    cycle(0, 0, 1, 0, 0, 0);   // R5 abort in ready
    cycle(0, 1, 0, 0, 0, 0);   // R3 to empty
    cycle(1, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 1, 1);   // R7 error limit 0 -> failed
    check("R7", int'(bufState), 5);
    retxLimit = 4'd1;
    cycle(1, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 1, 1);   // R7 retry -> ready
    check("R7", int'(bufState), 1);
    cycle(0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 1, 1);   // R7 limit reached -> failed
    check("R7", int'(bufState), 5);
    cycle(1, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    cycle(0, 0, 1, 0, 1, 2);   // R8 abort with arb-loss unlock -> aborted
    check("R8", int'(bufState), 4);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) retxLimit = CNT_W'($urandom_range(0, 3));
      cycle($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
            $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, 2) == 0, int'($urandom_range(0, 3)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule